// File: doc/BRIEF.md
# Mode-Banked Condition Flags and Return-Address Stack

This block is the control-context unit of a small 8-bit processor core. It keeps one carry/zero flag pair for each of three execution modes (normal, interrupt, non-maskable interrupt). Only the pair of the current mode is visible at the outputs, and only that pair takes ALU flag writes. Mode changes follow the interrupt and return strobes from the instruction sequencer: an accepted interrupt or NMI switches mode, and a return-from-interrupt goes back to the mode that was left.

The block also holds a return-address stack with no pointer. Its levels are shift registers. A call or an accepted interrupt shifts every level one deeper and loads the program counter at the top. A return shifts the levels back toward the top and presents the old top as the address to resume at. The stack saturates at both ends: when it is full, a push drops the deepest entry, and a return on an empty stack does nothing.

Top module: `ctx_flag_stack`

## Requirements
- R1: After reset, `mode_out` is 2'b10 (NMI mode), all three flag pairs hold zero, `stack_empty` is high and `pop_valid` is low.
- R2: `mode_out` encodes 2'b00 normal, 2'b01 interrupt and 2'b10 NMI. `carry_out`/`zero_out` show the pair of the current mode. When `flag_we` is high at a clock edge, `carry_in`/`zero_in` are stored into the pair of the mode in force before that edge, and no other pair changes.
- R3: `ev_irq` is accepted only in normal mode, and only when no accepted NMI arrives in the same cycle. It then enters interrupt mode. In any other case it has no effect on the mode or the stack.
- R4: `ev_nmi` is accepted in normal or interrupt mode, enters NMI mode and records the mode it left. In NMI mode it is ignored. It takes precedence over `ev_irq` in the same cycle.
- R5: An effective `ev_reti` returns from NMI mode to the recorded mode (normal when NMI mode was entered by reset), returns from interrupt mode to normal, and leaves normal mode unchanged.
- R6: A flag pair keeps its value while its mode is inactive and shows it again when its mode is re-entered.
- R7: A push (`ev_call`, or an accepted interrupt or NMI; one push per cycle at most) stores `pc_in` at level 1. Each older level moves one deeper, the level-6 value is lost, and the occupancy saturates at 6.
- R8: `ev_ret` or `ev_reti` with no push in the same cycle and a non-empty stack drives `pop_valid` high in that cycle, with `pop_pc` equal to level 1. At the clock edge the levels shift toward level 1 and the vacated deepest level becomes zero.
- R9: A return on an empty stack leaves `pop_valid` low and the stack unchanged.
- R10: When a push and a return coincide, the push is performed and the return (including any mode change from `ev_reti`) is ignored.
- R11: `stack_empty` is high exactly when no entries are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_call | input | 1 | Subroutine call strobe |
| ev_irq | input | 1 | Maskable interrupt entry strobe |
| ev_nmi | input | 1 | Non-maskable interrupt entry strobe |
| ev_ret | input | 1 | Subroutine return strobe |
| ev_reti | input | 1 | Return-from-interrupt strobe |
| pc_in | input | ADDR_W | Address pushed on a push |
| flag_we | input | 1 | Write enable for the active flag pair |
| carry_in | input | 1 | Carry result from the ALU |
| zero_in | input | 1 | Zero result from the ALU |
| carry_out | output | 1 | Carry of the active pair |
| zero_out | output | 1 | Zero of the active pair |
| mode_out | output | 2 | Current execution mode |
| pop_pc | output | ADDR_W | Level 1 of the stack, the resume address |
| pop_valid | output | 1 | A return is popping a valid entry this cycle |
| stack_empty | output | 1 | No entries held |

## Verification
The bench builds the block with its default values, a 12-bit address and six levels. The stack is shallow, so a few cycles of pushes reach the full end, where the deepest entry is dropped, and the empty end, where a return does nothing. A long swept sequence applies every combination of the five event strobes from each of the three modes, with different flag writes alongside. The expected flags, mode, occupancy and popped addresses come from an arithmetic model of the requirements. This covers every precedence case among push, return and the two interrupt kinds, including NMI nested over interrupt mode.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic [1:0] {
    MODE_NORM = 2'b00,
    MODE_IRQ  = 2'b01,
    MODE_NMI  = 2'b10
  } ctx_mode_e;

  localparam int NUM_MODES = 3;
endpackage

// File: rtl/ctx_mode_ctrl.sv
module ctx_mode_ctrl
  import ctx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ev_call,
  input  logic      ev_irq,
  input  logic      ev_nmi,
  input  logic      ev_ret,
  input  logic      ev_reti,
  output ctx_mode_e mode_q,
  output logic      push,
  output logic      pop_req
);
  ctx_mode_e mode_d;
  logic      back_irq_q, back_irq_d;   // NMI was entered from interrupt mode
  logic      nmi_acc, irq_acc, reti_eff;

  // Acceptance depends only on the registered mode
  assign nmi_acc  = ev_nmi && (mode_q != MODE_NMI);
  assign irq_acc  = ev_irq && (mode_q == MODE_NORM) && !nmi_acc;
  assign push     = ev_call || nmi_acc || irq_acc;
  assign reti_eff = ev_reti && !push;
  assign pop_req  = (ev_ret || ev_reti) && !push;

  always_comb begin
    mode_d     = mode_q;
    back_irq_d = back_irq_q;
    if (nmi_acc) begin
      mode_d     = MODE_NMI;
      back_irq_d = (mode_q == MODE_IRQ);
    end else if (irq_acc) begin
      mode_d = MODE_IRQ;
    end else if (reti_eff) begin
      unique case (mode_q)
        MODE_NMI: mode_d = back_irq_q ? MODE_IRQ : MODE_NORM;
        default:  mode_d = MODE_NORM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_NMI;
      back_irq_q <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      back_irq_q <= back_irq_d;
    end
  end
endmodule

// File: rtl/ctx_flag_bank.sv
module ctx_flag_bank
  import ctx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ctx_mode_e mode_q,
  input  logic      flag_we,
  input  logic      carry_in,
  input  logic      zero_in,
  output logic      carry_out,
  output logic      zero_out
);
  logic [NUM_MODES-1:0] c_all;
  logic [NUM_MODES-1:0] z_all;

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_pair
    logic c_q, z_q, c_d, z_d, hit;

    assign hit = flag_we && (mode_q == ctx_mode_e'(g));

    always_comb begin
      c_d = c_q;
      z_d = z_q;
      if (hit) begin
        c_d = carry_in;
        z_d = zero_in;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q <= 1'b0;
        z_q <= 1'b0;
      end else begin
        c_q <= c_d;
        z_q <= z_d;
      end
    end

    assign c_all[g] = c_q;
    assign z_all[g] = z_q;
  end

  always_comb begin
    unique case (mode_q)
      MODE_NORM: begin carry_out = c_all[0]; zero_out = z_all[0]; end
      MODE_IRQ:  begin carry_out = c_all[1]; zero_out = z_all[1]; end
      default:   begin carry_out = c_all[2]; zero_out = z_all[2]; end
    endcase
  end
endmodule

// File: rtl/ctx_ret_stack.sv
module ctx_ret_stack #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop_req,
  input  logic [ADDR_W-1:0] pc_in,
  output logic [ADDR_W-1:0] top,
  output logic              pop_valid,
  output logic              empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DEPTH-1:0][ADDR_W-1:0] lvl_q, lvl_d;
  logic [CW-1:0]                cnt_q, cnt_d;

  assign empty     = (cnt_q == '0);
  assign pop_valid = pop_req && !push && !empty;
  assign top       = lvl_q[0];

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (push) begin
      lvl_d[0] = pc_in;
      for (int i = 1; i < DEPTH; i++) lvl_d[i] = lvl_q[i-1];
      if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
    end else if (pop_valid) begin
      for (int i = 0; i < DEPTH - 1; i++) lvl_d[i] = lvl_q[i+1];
      lvl_d[DEPTH-1] = '0;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ctx_flag_stack.sv
module ctx_flag_stack
  import ctx_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_call,
  input  logic              ev_irq,
  input  logic              ev_nmi,
  input  logic              ev_ret,
  input  logic              ev_reti,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              flag_we,
  input  logic              carry_in,
  input  logic              zero_in,
  output logic              carry_out,
  output logic              zero_out,
  output logic [1:0]        mode_out,
  output logic [ADDR_W-1:0] pop_pc,
  output logic              pop_valid,
  output logic              stack_empty
);
  ctx_mode_e mode_q;
  logic      push, pop_req;

  ctx_mode_ctrl i_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_call (ev_call),
    .ev_irq  (ev_irq),
    .ev_nmi  (ev_nmi),
    .ev_ret  (ev_ret),
    .ev_reti (ev_reti),
    .mode_q  (mode_q),
    .push    (push),
    .pop_req (pop_req)
  );

  ctx_flag_bank i_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .flag_we   (flag_we),
    .carry_in  (carry_in),
    .zero_in   (zero_in),
    .carry_out (carry_out),
    .zero_out  (zero_out)
  );

  ctx_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop_req   (pop_req),
    .pc_in     (pc_in),
    .top       (pop_pc),
    .pop_valid (pop_valid),
    .empty     (stack_empty)
  );

  assign mode_out = mode_q;
endmodule

// File: rtl/ctx_flag_stack_chk.sv
module ctx_flag_stack_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_call,
  input logic       ev_irq,
  input logic       ev_nmi,
  input logic       ev_ret,
  input logic       ev_reti,
  input logic       flag_we,
  input logic       carry_in,
  input logic       zero_in,
  input logic       carry_out,
  input logic       zero_out,
  input logic [1:0] mode_out,
  input logic       pop_valid,
  input logic       stack_empty
);
  // R4
  nmi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_nmi && mode_out != 2'b10) |=> (mode_out == 2'b10));

  // R3
  irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_irq && !ev_nmi && mode_out == 2'b00) |=> (mode_out == 2'b01));

  // R5
  irq_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_reti && !ev_call && !ev_irq && !ev_nmi && mode_out == 2'b01)
      |=> (mode_out == 2'b00));

  // R2
  flag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !ev_nmi && !ev_irq && !ev_reti)
      |=> (carry_out == $past(carry_in) && zero_out == $past(zero_in)));

  // R7
  push_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_call |=> !stack_empty);

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_empty && (ev_ret || ev_reti) && !ev_call && !ev_irq && !ev_nmi)
      |-> !pop_valid);

  // R11
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_empty && !ev_call && !ev_irq && !ev_nmi) |=> stack_empty);
endmodule

bind ctx_flag_stack ctx_flag_stack_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_call     (ev_call),
  .ev_irq      (ev_irq),
  .ev_nmi      (ev_nmi),
  .ev_ret      (ev_ret),
  .ev_reti     (ev_reti),
  .flag_we     (flag_we),
  .carry_in    (carry_in),
  .zero_in     (zero_in),
  .carry_out   (carry_out),
  .zero_out    (zero_out),
  .mode_out    (mode_out),
  .pop_valid   (pop_valid),
  .stack_empty (stack_empty)
);

// File: tb/test_ctx_flag_stack.sv
module test_ctx_flag_stack;
  localparam int AW = 12;
  localparam int DP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_call = 0, ev_irq = 0, ev_nmi = 0, ev_ret = 0, ev_reti = 0;
  logic [AW-1:0] pc_in = '0;
  logic flag_we = 0, carry_in = 0, zero_in = 0;
  logic carry_out, zero_out, pop_valid, stack_empty;
  logic [1:0] mode_out;
  logic [AW-1:0] pop_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Model state
  int m_mode;             // 0 normal, 1 interrupt, 2 NMI
  int m_back;             // mode restored on reti from NMI
  bit m_c[3];
  bit m_z[3];
  int m_stk[DP];
  int m_cnt;

  always #4 clk = ~clk;   // 125 MHz

  ctx_flag_stack #(.ADDR_W(AW), .DEPTH(DP)) i_ctx_flag_stack (
    .clk(clk), .rst_n(rst_n), .ev_call(ev_call), .ev_irq(ev_irq),
    .ev_nmi(ev_nmi), .ev_ret(ev_ret), .ev_reti(ev_reti), .pc_in(pc_in),
    .flag_we(flag_we), .carry_in(carry_in), .zero_in(zero_in),
    .carry_out(carry_out), .zero_out(zero_out), .mode_out(mode_out),
    .pop_pc(pop_pc), .pop_valid(pop_valid), .stack_empty(stack_empty)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(req, "mode_out", int'(mode_out), m_mode);
    chk(req, "carry_out", int'(carry_out), int'(m_c[m_mode]));
    chk(req, "zero_out", int'(zero_out), int'(m_z[m_mode]));
    chk("R11", "stack_empty", int'(stack_empty), int'(m_cnt == 0));
    if (m_cnt > 0) chk(req, "pop_pc level 1", int'(pop_pc), m_stk[0]);
  endtask

  // One cycle with the given strobes; model follows the requirements
  task automatic step(input bit c, input bit i, input bit n, input bit r, input bit ri,
                      input bit we, input bit ci, input bit zi, input int pc,
                      input string req);
    bit nmi_acc, irq_acc, push, popr, popv;
    @(negedge clk);
    ev_call = c; ev_irq = i; ev_nmi = n; ev_ret = r; ev_reti = ri;
    flag_we = we; carry_in = ci; zero_in = zi; pc_in = AW'(pc);
    nmi_acc = n && (m_mode != 2);
    irq_acc = i && (m_mode == 0) && !nmi_acc;
    push    = c || nmi_acc || irq_acc;
    popr    = (r || ri) && !push;
    popv    = popr && (m_cnt > 0);
    #1;
    chk(popv ? "R8" : (popr ? "R9" : "R10"), "pop_valid", int'(pop_valid), int'(popv));
    if (popv) chk("R8", "pop_pc", int'(pop_pc), m_stk[0]);
    @(posedge clk);
    if (we) begin m_c[m_mode] = ci; m_z[m_mode] = zi; end
    if (push) begin
      for (int k = DP - 1; k > 0; k--) m_stk[k] = m_stk[k-1];
      m_stk[0] = pc % (1 << AW);
      if (m_cnt < DP) m_cnt++;
    end else if (popv) begin
      for (int k = 0; k < DP - 1; k++) m_stk[k] = m_stk[k+1];
      m_stk[DP-1] = 0;
      m_cnt--;
    end
    if (nmi_acc) begin m_back = m_mode; m_mode = 2; end
    else if (irq_acc) m_mode = 1;
    else if (ri && !push) m_mode = (m_mode == 2) ? m_back : 0;
    #1;
    check_state(req);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_mode = 2; m_back = 0; m_cnt = 0;
    for (int k = 0; k < 3; k++) begin m_c[k] = 0; m_z[k] = 0; end
    for (int k = 0; k < DP; k++) m_stk[k] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "mode_out", int'(mode_out), 2);
    chk("R1", "carry_out", int'(carry_out), 0);
    chk("R1", "zero_out", int'(zero_out), 0);
    chk("R1", "stack_empty", int'(stack_empty), 1);
    chk("R1", "pop_valid", int'(pop_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 write NMI pair, R5 reti from reset NMI goes to normal
    step(0,0,0,0,0, 1,1,0, 0, "R2");
    step(0,0,0,0,1, 0,0,0, 0, "R5");
    step(0,0,0,0,0, 1,0,1, 0, "R2");
    // R3 irq entry pushes, R6 irq pair initially zero
    step(0,1,0,0,0, 0,0,0, 12'h123, "R3");
    step(0,1,0,0,0, 0,0,0, 12'h124, "R3");   // ignored in interrupt mode
    step(0,0,0,0,0, 1,1,1, 0, "R2");
    // R4 NMI over interrupt, R6 NMI pair kept
    step(0,0,1,0,0, 0,0,0, 12'h456, "R4");
    step(0,0,1,0,0, 0,0,0, 12'h457, "R4");   // ignored in NMI mode
    step(0,0,0,0,1, 0,0,0, 0, "R5");
    step(0,0,0,0,1, 0,0,0, 0, "R5");
    step(0,0,0,0,1, 0,0,0, 0, "R6");         // empty, stays normal
    // R4 NMI wins over irq from normal
    step(0,1,1,0,0, 0,0,0, 12'h0AA, "R4");
    step(0,0,0,0,1, 0,0,0, 0, "R5");
    // R7 saturation at the full end
    for (int k = 0; k < DP + 2; k++) step(1,0,0,0,0, 0,0,0, 100 + k, "R7");
    // R10 push and return together
    step(1,0,0,1,0, 0,0,0, 12'hFFF, "R10");
    step(1,0,0,0,1, 0,0,0, 12'hFFE, "R10");
    // R8 drain and R9 underflow
    for (int k = 0; k < DP + 2; k++) step(0,0,0,1,0, 0,0,0, 0, k < DP ? "R8" : "R9");

    // Swept strobe combinations from every mode
    for (int s = 0; s < 1200; s++) begin
      int ev;
      ev = (s * 11 + (s >> 5)) & 31;
      if ((s % 3) == 0) ev = ev & 5'b11000;   // returns more frequent
      step(ev[0], ev[1] & (s[2]), ev[2] & s[3] & s[4], ev[3], ev[4],
           s[0], s[1] ^ s[4], s[2] ^ s[5], s * 37 + 5, "R7");
    end

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule